// File: doc/BRIEF.md
# Tracking Position Counter with Range Flags

This block is the digital back end of a ratiometric tracking converter. An external loop delivers one pulse per least significant bit of motion, with a direction bit alongside it. The block keeps a position count that follows the ratio of the differential signal to half the reference amplitude, and turns that count into a 13-bit offset-binary displacement together with overrange, underrange and null indications.

The count covers three quadrants: the operating range, one full quadrant above it and one full quadrant below it. When the count is outside the operating range, the displacement word keeps showing the low 13 bits of the count, so the range flags together with the displacement extend the usable travel. When motion is driven past the outer quadrants, the count saturates and a lost-track flag rises. The flag clears once the count is back inside the operating range. A mode input picks one of two slew limits. A pulse that arrives sooner after the previous one than the selected limit allows is still counted, but it raises an overspeed flag.

Top module: `trk_position_tracker`

## Requirements
- R1: A cycle with `pulse_i` high moves the position by exactly +1 when `dir_i`=1 and by exactly -1 when `dir_i`=0. A cycle with `pulse_i` low leaves the position unchanged.
- R2: While `rst_ni` is low, and after it is released, the position is zero: `disp_o`=0x1000, `null_o`=1, and `ovr_o`, `unr_o`, `lost_o` and `overspeed_o` are all 0.
- R3: For a position p in the operating range -4096..+4095, `disp_o` = p + 4096. So -4096 shows 0x0000 and +4095 shows 0x1FFF.
- R4: `null_o` is 1 exactly when the position is 0.
- R5: `ovr_o` is 1 exactly when p >= +4096. `unr_o` is 1 exactly when p < -4096. The two are never 1 together.
- R6: Outside the operating range, `disp_o` = (p + 4096) mod 8192. For example, p=+4096 shows 0x0000 and p=-4097 shows 0x1FFF.
- R7: The position saturates at +12287 and -12288. A pulse that pushes outward at either limit leaves the position unchanged and sets `lost_o`. `lost_o` returns to 0 once the position is back in -4096..+4095.
- R8: The minimum pulse spacing is CLK_KHZ/2400 cycles when `mode_i`=0 and CLK_KHZ/800 cycles when `mode_i`=1. A pulse that follows the previous one by fewer cycles sets `overspeed_o`, and is still counted. A pulse at or above the spacing clears `overspeed_o`.
- R9: The first pulse after reset never sets `overspeed_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | One-LSB motion pulse, one cycle wide |
| dir_i | input | 1 | 1 = count up, 0 = count down |
| mode_i | input | 1 | Slew mode: 0 = fast limit, 1 = slow limit |
| disp_o | output | 13 | Offset-binary displacement |
| ovr_o | output | 1 | Position above the operating range |
| unr_o | output | 1 | Position below the operating range |
| null_o | output | 1 | Position exactly zero |
| lost_o | output | 1 | Tracking lost at a saturation limit |
| overspeed_o | output | 1 | Last pulse came too soon for the selected mode |

## Verification
Small moves in both directions around zero show whether the sign and the unit step are right, and whether the null flag is tied to the exact zero code. Single steps across +4095/+4096 and -4096/-4097 separate the in-range wrap of the displacement from the range flags. Long runs into each outer limit, followed by returns, separate saturation and the setting of lost-track from its clearing. Pulse pairs spaced one cycle below and exactly at each mode's spacing pin down the overspeed threshold, and also confirm that fast pulses are still counted.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [1:0] {
    QUAD_UNDER = 2'b00,
    QUAD_IN    = 2'b01,
    QUAD_OVER  = 2'b10,
    QUAD_BAD   = 2'b11
  } quad_e;

  function automatic int min_gap(input int clk_khz, input int rate_lsb_ms);
    int g;
    g = clk_khz / rate_lsb_ms;
    return (g < 1) ? 1 : g;
  endfunction
endpackage

// File: rtl/trk_rate_guard.sv
module trk_rate_guard #(
  parameter int GAP_FAST = 41,
  parameter int GAP_SLOW = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic mode_i,
  output logic overspeed_o
);
  localparam int GAP_SAT = (GAP_SLOW > GAP_FAST) ? GAP_SLOW : GAP_FAST;
  localparam int GAP_W   = $clog2(GAP_SAT + 1);

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] min_gap;
  logic             over_q;

  assign min_gap = mode_i ? GAP_W'(GAP_SLOW) : GAP_W'(GAP_FAST);

  // gap_q = cycles since last pulse, saturating; reset to saturated so first pulse is legal
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= GAP_W'(GAP_SAT);
      over_q <= 1'b0;
    end else if (pulse_i) begin
      gap_q  <= GAP_W'(1);
      over_q <= (gap_q < min_gap);
    end else if (gap_q != GAP_W'(GAP_SAT)) begin
      gap_q  <= gap_q + GAP_W'(1);
    end
  end

  assign overspeed_o = over_q;

  AST_NO_FLAG_WITHOUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> $stable(over_q)); // R8

  AST_GAP_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q != '0); // R9
endmodule

// File: rtl/trk_updown.sv
module trk_updown #(
  parameter int POS_W = 15,
  parameter logic [POS_W-1:0] POS_MAX  = '1,
  parameter logic [POS_W-1:0] NULL_POS = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             in_range_i,
  output logic [POS_W-1:0] pos_o,
  output logic             lost_o
);
  logic [POS_W-1:0] pos_q;
  logic             lost_q;
  logic             at_top, at_bot, sat_hit;

  assign at_top  = (pos_q == POS_MAX);
  assign at_bot  = (pos_q == '0);
  assign sat_hit = step_i && ((up_i && at_top) || (!up_i && at_bot));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= NULL_POS;
    end else if (step_i && !sat_hit) begin
      pos_q <= up_i ? pos_q + POS_W'(1) : pos_q - POS_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lost_q <= 1'b0;
    else if (sat_hit)    lost_q <= 1'b1;
    else if (in_range_i) lost_q <= 1'b0;
  end

  assign pos_o  = pos_q;
  assign lost_o = lost_q;

  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && up_i && !at_top |=> pos_q == $past(pos_q) + POS_W'(1)); // R1

  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !up_i && !at_bot |=> pos_q == $past(pos_q) - POS_W'(1)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_q)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= POS_MAX); // R7

  AST_LOST_ON_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && up_i && at_top |=> lost_q && $stable(pos_q)); // R7

  AST_LOST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_q && in_range_i |=> !lost_q); // R7
endmodule

// File: rtl/trk_decode.sv
module trk_decode
  import trk_pkg::*;
#(
  parameter int DISP_W = 13,
  parameter int POS_W  = DISP_W + 2,
  parameter logic [POS_W-1:0] NULL_POS = '0
) (
  input  logic [POS_W-1:0]  pos_i,
  output logic [DISP_W-1:0] disp_o,
  output logic              ovr_o,
  output logic              unr_o,
  output logic              null_o,
  output logic              in_range_o
);
  quad_e quad;

  assign quad       = quad_e'(pos_i[POS_W-1 -: 2]);
  assign ovr_o      = (quad == QUAD_OVER);
  assign unr_o      = (quad == QUAD_UNDER);
  assign in_range_o = (quad == QUAD_IN);
  // low bits stay valid in every quadrant
  assign disp_o     = pos_i[DISP_W-1:0];
  assign null_o     = (pos_i == NULL_POS);
endmodule

// File: rtl/trk_position_tracker.sv
module trk_position_tracker
  import trk_pkg::*;
#(
  parameter int DISP_W       = 13,
  parameter int CLK_KHZ      = 100000,
  parameter int RATE_FAST_MS = 2400,
  parameter int RATE_SLOW_MS = 800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              dir_i,
  input  logic              mode_i,
  output logic [DISP_W-1:0] disp_o,
  output logic              ovr_o,
  output logic              unr_o,
  output logic              null_o,
  output logic              lost_o,
  output logic              overspeed_o
);
  localparam int POS_W = DISP_W + 2;
  localparam logic [POS_W-1:0] POS_MAX  = POS_W'(3 * (1 << DISP_W) - 1);
  localparam logic [POS_W-1:0] NULL_POS = POS_W'(3 * (1 << (DISP_W - 1)));
  localparam int GAP_FAST = min_gap(CLK_KHZ, RATE_FAST_MS);
  localparam int GAP_SLOW = min_gap(CLK_KHZ, RATE_SLOW_MS);

  logic [POS_W-1:0] pos;
  logic             in_range;

  trk_updown #(
    .POS_W(POS_W), .POS_MAX(POS_MAX), .NULL_POS(NULL_POS)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(pulse_i), .up_i(dir_i),
    .in_range_i(in_range), .pos_o(pos), .lost_o(lost_o)
  );

  trk_decode #(
    .DISP_W(DISP_W), .POS_W(POS_W), .NULL_POS(NULL_POS)
  ) u_dec (
    .pos_i(pos), .disp_o(disp_o), .ovr_o(ovr_o), .unr_o(unr_o),
    .null_o(null_o), .in_range_o(in_range)
  );

  trk_rate_guard #(
    .GAP_FAST(GAP_FAST), .GAP_SLOW(GAP_SLOW)
  ) u_rate (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(pulse_i), .mode_i(mode_i),
    .overspeed_o(overspeed_o)
  );

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovr_o, unr_o, null_o})); // R5

  AST_NULL_MIDCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    null_o |-> disp_o == DISP_W'(1 << (DISP_W - 1))); // R4

  AST_LOST_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lost_o) |-> (ovr_o || unr_o)); // R7
endmodule

// File: tb/trk_position_tracker_tb_top.sv
module trk_position_tracker_tb_top;
  localparam int CLK_KHZ = 24000;
  localparam int GAP_F   = 10;   // 24000/2400
  localparam int GAP_S   = 30;   // 24000/800
  localparam int PMAX    = 12287;
  localparam int PMIN    = -12288;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pulse_i = 1'b0, dir_i = 1'b0, mode_i = 1'b0;
  logic [12:0] disp_o;
  logic        ovr_o, unr_o, null_o, lost_o, overspeed_o;

  int n_chk = 0, n_fail = 0;
  int p_ref = 0;
  bit lost_ref = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trk_position_tracker #(.CLK_KHZ(CLK_KHZ)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pulse_i(pulse_i), .dir_i(dir_i), .mode_i(mode_i),
    .disp_o(disp_o), .ovr_o(ovr_o), .unr_o(unr_o), .null_o(null_o),
    .lost_o(lost_o), .overspeed_o(overspeed_o)
  );

  task automatic step(input bit up, input int n, input int sp);
    for (int i = 0; i < n; i++) begin
      pulse_i = 1'b1; dir_i = up;
      @(negedge clk);
      pulse_i = 1'b0;
      if (up) begin
        if (p_ref == PMAX) lost_ref = 1'b1; else p_ref++;
      end else begin
        if (p_ref == PMIN) lost_ref = 1'b1; else p_ref--;
      end
      if (p_ref >= -4096 && p_ref <= 4095) lost_ref = 1'b0;
      repeat (sp - 1) @(negedge clk);
    end
  endtask

  task automatic check_pos(input string req);
    int ed; bit eo, eu, en;
    @(negedge clk);
    ed = ((p_ref + 4096) % 8192 + 8192) % 8192;
    eo = (p_ref >= 4096); eu = (p_ref < -4096); en = (p_ref == 0);
    n_chk++;
    if (int'(disp_o) != ed || ovr_o != eo || unr_o != eu || null_o != en || lost_o != lost_ref) begin
      n_fail++;
      $display("FAIL %s p=%0d: disp/ovr/unr/null/lost act %h/%b/%b/%b/%b exp %h/%b/%b/%b/%b",
               req, p_ref, disp_o, ovr_o, unr_o, null_o, lost_o, ed[12:0], eo, eu, en, lost_ref);
    end
  endtask

  task automatic check_os(input string req, input bit exp);
    n_chk++;
    if (overspeed_o != exp) begin
      n_fail++;
      $display("FAIL %s overspeed act %b exp %b", req, overspeed_o, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; pulse_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    p_ref = 0; lost_ref = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check_pos("R2 reset");
    check_os("R2 reset", 1'b0);
  endtask

  task automatic t_small_moves();
    step(1'b1, 5, GAP_F);  check_pos("R1 R3 up 5");
    step(1'b0, 10, GAP_F); check_pos("R1 R3 down 10");
    step(1'b1, 5, 1);      check_pos("R4 back to null");
    step(1'b1, 1, 1);      check_pos("R4 one above null");
  endtask

  task automatic t_upper_edge();
    step(1'b1, 4094, 1); check_pos("R3 full scale +4095");
    step(1'b1, 1, 1);    check_pos("R5 R6 first overrange code");
    step(1'b1, 200, 1);  check_pos("R6 inside overrange");
  endtask

  task automatic t_upper_sat();
    step(1'b1, PMAX - p_ref, 1); check_pos("R7 at upper limit");
    step(1'b1, 3, 1);            check_pos("R7 saturate and lost");
    step(1'b0, PMAX - 4095, 1);  check_pos("R7 lost clears in range");
  endtask

  task automatic t_lower();
    step(1'b0, 4095 + 4096, 1); check_pos("R3 full scale -4096");
    step(1'b0, 1, 1);           check_pos("R5 R6 first underrange code");
    step(1'b0, p_ref - PMIN, 1); check_pos("R7 at lower limit");
    step(1'b0, 2, 1);           check_pos("R7 lower saturate lost");
    step(1'b1, 8192, 1);        check_pos("R7 lower recovery");
  endtask

  task automatic t_overspeed();
    do_reset();
    step(1'b1, 1, 1); check_os("R9 first pulse", 1'b0);
    mode_i = 1'b0;
    step(1'b1, 2, GAP_F - 1); check_os("R8 fast mode gap-1", 1'b1);
    check_pos("R8 fast pulses counted");
    step(1'b1, 2, GAP_F);     check_os("R8 fast mode at gap", 1'b0);
    mode_i = 1'b1;
    step(1'b0, 2, GAP_S - 1); check_os("R8 slow mode gap-1", 1'b1);
    step(1'b0, 2, GAP_S);     check_os("R8 slow mode at gap", 1'b0);
    check_pos("R1 R8 net position");
    mode_i = 1'b0;
  endtask

  task automatic t_reset_mid();
    step(1'b1, 5000, 1);
    do_reset();
    check_pos("R2 reset from overrange");
    check_os("R2 reset clears overspeed", 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_small_moves();
    t_upper_edge();
    t_upper_sat();
    t_lower();
    t_overspeed();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act running exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule